// File: doc/BRIEF.md
# Load/Store Port Requester

This block sits on the compute side of a load/store port. It accepts one memory command at a time from a valid/ready command interface. A command is a load or a store, with an address and, for a store, write data. The block carries the command through the port handshake and then reports the outcome as a single-cycle result pulse. The result carries either the loaded word, a store-completion flag or an address-exception flag.

Toward the port, the block raises exactly one request strobe together with an address-valid flag and the address. It holds all three until the port's busy signal is seen low. It then waits for a one-cycle address-accept or address-exception pulse. For a store, it presents the write data with a one-cycle write-valid strobe only after the accept pulse. For a load, it captures read data in the single cycle that read-valid is high. A kill input abandons the transaction in progress and returns the block to idle.

Top module: `ldst_requester`

## Requirements
- R1: `cmd_ready_o` is high only while idle and `kill_i` is low. It stays low from the accepting edge through the result cycle and is high again in the cycle after the result.
- R2: In the cycle after a command is accepted, exactly one strobe is high: `port_st_o` when `cmd_store_i` was 1, `port_ld_o` when it was 0. `port_addr_valid_o` is high and `port_addr_o` equals the command address in that same cycle.
- R3: While `port_addr_valid_o` stays high, `port_addr_o` does not change. The strobe and `port_addr_valid_o` stay high until `port_busy_i` has been seen low.
- R4: `port_wvalid_o` is high for exactly one cycle per store, in the cycle right after the `port_addr_ack_i` pulse, with `port_wdata_o` equal to the command write data. It is never high for a load.
- R5: For a load, the word on `port_rdata_i` in the cycle that `port_rvalid_i` is high appears on `res_rdata_o` one cycle later, with `res_valid_o`=1, `res_store_o`=0 and `res_exc_o`=0. A store followed by a load of the same address returns the stored word.
- R6: An `port_addr_exc_i` pulse ends the transaction. One cycle later `res_valid_o`=1 and `res_exc_o`=1, and no write-valid strobe is issued.
- R7: A store completes with `res_valid_o`=1, `res_store_o`=1 and `res_exc_o`=0, two cycles after its write-valid cycle, once busy has been seen low.
- R8: In the result cycle both request strobes are low, and no strobe is raised again before a new command is accepted.
- R9: When `kill_i` is high at a clock edge, all port outputs are low after that edge, no result is produced for the abandoned command, and the block is idle.
- R10: After reset, `cmd_ready_o`=1 and every port output and `res_valid_o` is 0.
- R11: `res_valid_o` is high for exactly one cycle per completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kill_i | input | 1 | Abandon current transaction, return to idle |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_wdata_i | input | DATA_W | Store data |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_store_o | output | 1 | Result is a store completion |
| res_exc_o | output | 1 | Result is an address exception |
| res_rdata_o | output | DATA_W | Load data, meaningful for a load result |
| port_ld_o | output | 1 | Load request strobe |
| port_st_o | output | 1 | Store request strobe |
| port_addr_valid_o | output | 1 | Address is valid |
| port_addr_o | output | ADDR_W | Request address |
| port_wdata_o | output | DATA_W | Store data toward port |
| port_wvalid_o | output | 1 | Store data valid, one cycle |
| port_busy_i | input | 1 | Port transaction in progress |
| port_addr_ack_i | input | 1 | Address accepted pulse |
| port_addr_exc_i | input | 1 | Address exception pulse |
| port_rvalid_i | input | 1 | Load data valid pulse |
| port_rdata_i | input | DATA_W | Load data |

## Verification
Strobes and the address are due in the first cycle after the accepting edge. Write-valid is due one cycle after the accept pulse. A load or exception result is due one cycle after its read-valid or exception pulse, and a store result two cycles after its write-valid cycle. The monitor records the cycle number of each accept, exception, read-valid and write-valid pulse, sampling mid-cycle. When a result appears, it checks the gap against the expected count as well as the payload queued by the driver. The responder delays are varied per command so that these gaps are measured under different waits.

// File: rtl/ldst_req_pkg.sv
package ldst_req_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LDWAIT,
    ST_WDATA,
    ST_DRAIN,
    ST_DONE
  } req_state_e;

  typedef enum logic [1:0] {
    RES_LOAD,
    RES_STORE,
    RES_EXC
  } res_kind_e;

endpackage

// File: rtl/ldst_req_cmd_reg.sv
module ldst_req_cmd_reg #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              store_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      store_o <= store_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

endmodule

// File: rtl/ldst_req_fsm.sv
module ldst_req_fsm
  import ldst_req_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic cmd_valid_i,
  input  logic store_i,
  input  logic busy_i,
  input  logic ack_i,
  input  logic exc_i,
  input  logic rvalid_i,
  output logic cmd_ready_o,
  output logic accept_o,
  output logic active_o,
  output logic wvalid_o,
  output logic capture_o,
  output logic res_valid_o,
  output logic res_store_o,
  output logic res_exc_o
);

  req_state_e state_q, state_d;
  res_kind_e  kind_q, kind_d;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    if (kill_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (cmd_valid_i) state_d = ST_ADDR;
        ST_ADDR: begin
          if (exc_i) begin
            state_d = ST_DONE;
            kind_d  = RES_EXC;
          end else if (ack_i) begin
            state_d = store_i ? ST_WDATA : ST_LDWAIT;
          end
        end
        ST_LDWAIT: begin
          // busy drops with rvalid, so the port is already free
          if (rvalid_i) begin
            state_d = ST_DONE;
            kind_d  = RES_LOAD;
          end
        end
        ST_WDATA:  state_d = ST_DRAIN;
        ST_DRAIN: begin
          if (!busy_i) begin
            state_d = ST_DONE;
            kind_d  = RES_STORE;
          end
        end
        ST_DONE:   state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= RES_LOAD;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE) && !kill_i;
  assign accept_o    = cmd_ready_o && cmd_valid_i;
  assign active_o    = (state_q == ST_ADDR) || (state_q == ST_LDWAIT) ||
                       (state_q == ST_WDATA) || (state_q == ST_DRAIN);
  assign wvalid_o    = (state_q == ST_WDATA);
  assign capture_o   = (state_q == ST_LDWAIT) && rvalid_i && !kill_i;
  assign res_valid_o = (state_q == ST_DONE);
  assign res_store_o = res_valid_o && (kind_q == RES_STORE);
  assign res_exc_o   = res_valid_o && (kind_q == RES_EXC);

endmodule

// File: rtl/ldst_req_result.sv
module ldst_req_result #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= rdata_i;
  end

endmodule

// File: rtl/ldst_requester.sv
module ldst_requester #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kill_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_store_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              res_valid_o,
  output logic              res_store_o,
  output logic              res_exc_o,
  output logic [DATA_W-1:0] res_rdata_o,
  output logic              port_ld_o,
  output logic              port_st_o,
  output logic              port_addr_valid_o,
  output logic [ADDR_W-1:0] port_addr_o,
  output logic [DATA_W-1:0] port_wdata_o,
  output logic              port_wvalid_o,
  input  logic              port_busy_i,
  input  logic              port_addr_ack_i,
  input  logic              port_addr_exc_i,
  input  logic              port_rvalid_i,
  input  logic [DATA_W-1:0] port_rdata_i
);

  logic              accept;
  logic              active;
  logic              wvalid;
  logic              capture;
  logic              store_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  ldst_req_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .store_i (cmd_store_i),
    .addr_i  (cmd_addr_i),
    .wdata_i (cmd_wdata_i),
    .store_o (store_q),
    .addr_o  (addr_q),
    .wdata_o (wdata_q)
  );

  ldst_req_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kill_i      (kill_i),
    .cmd_valid_i (cmd_valid_i),
    .store_i     (store_q),
    .busy_i      (port_busy_i),
    .ack_i       (port_addr_ack_i),
    .exc_i       (port_addr_exc_i),
    .rvalid_i    (port_rvalid_i),
    .cmd_ready_o (cmd_ready_o),
    .accept_o    (accept),
    .active_o    (active),
    .wvalid_o    (wvalid),
    .capture_o   (capture),
    .res_valid_o (res_valid_o),
    .res_store_o (res_store_o),
    .res_exc_o   (res_exc_o)
  );

  ldst_req_result #(.DATA_W(DATA_W)) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .rdata_i   (port_rdata_i),
    .rdata_o   (res_rdata_o)
  );

  assign port_ld_o         = active && !store_q;
  assign port_st_o         = active && store_q;
  assign port_addr_valid_o = active;
  assign port_addr_o       = active ? addr_q : '0;
  assign port_wvalid_o     = wvalid;
  assign port_wdata_o      = wvalid ? wdata_q : '0;

endmodule

// File: rtl/ldst_requester_chk.sv
module ldst_requester_chk #(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              kill_i,
  input logic              cmd_ready_o,
  input logic              res_valid_o,
  input logic              res_exc_o,
  input logic              port_ld_o,
  input logic              port_st_o,
  input logic              port_addr_valid_o,
  input logic [ADDR_W-1:0] port_addr_o,
  input logic              port_wvalid_o,
  input logic [DATA_W-1:0] port_wdata_o,
  input logic              port_addr_ack_i,
  input logic              port_addr_exc_i,
  input logic              port_rvalid_i
);

  AST_NOT_READY_AT_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !cmd_ready_o); // R1

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_ld_o && port_st_o)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_addr_valid_o && $past(port_addr_valid_o) && !$past(kill_i)) |-> $stable(port_addr_o)); // R3

  AST_WVALID_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wvalid_o |-> ($past(port_addr_ack_i) && port_st_o)); // R4

  AST_WVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wvalid_o |=> !port_wvalid_o); // R4

  AST_LOAD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rvalid_i && port_ld_o && !port_addr_valid_o == 1'b0 && !kill_i) |=> (res_valid_o && !res_exc_o)); // R5

  AST_EXC_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_addr_exc_i && port_addr_valid_o && !kill_i) |=> (res_valid_o && res_exc_o && !port_wvalid_o)); // R6

  AST_NO_STROBE_AT_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (!port_ld_o && !port_st_o && !port_addr_valid_o)); // R8

  AST_KILL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (!port_ld_o && !port_st_o && !port_addr_valid_o && !port_wvalid_o && !res_valid_o)); // R9

  AST_RESULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R11

  always_comb begin
    if (port_wvalid_o === 1'b0) begin
      AST_WDATA_QUIET: assert (port_wdata_o === '0 || !rst_ni); // R4
    end
  end

endmodule

bind ldst_requester ldst_requester_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .kill_i            (kill_i),
  .cmd_ready_o       (cmd_ready_o),
  .res_valid_o       (res_valid_o),
  .res_exc_o         (res_exc_o),
  .port_ld_o         (port_ld_o),
  .port_st_o         (port_st_o),
  .port_addr_valid_o (port_addr_valid_o),
  .port_addr_o       (port_addr_o),
  .port_wvalid_o     (port_wvalid_o),
  .port_wdata_o      (port_wdata_o),
  .port_addr_ack_i   (port_addr_ack_i),
  .port_addr_exc_i   (port_addr_exc_i),
  .port_rvalid_i     (port_rvalid_i)
);

// File: tb/ldst_requester_bench.sv
module ldst_requester_bench;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          kill = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_store = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          res_valid, res_store, res_exc;
  logic [DW-1:0] res_rdata;
  logic          p_ld, p_st, p_av, p_wv;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  logic          p_busy, p_ack, p_exc, p_rv;
  logic [DW-1:0] p_rdata;

  always #2 clk = ~clk;

  ldst_requester #(.ADDR_W(AW), .DATA_W(DW)) u_ldst_requester (
    .clk_i(clk), .rst_ni(rst_n), .kill_i(kill),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_store_i(cmd_store),
    .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
    .res_valid_o(res_valid), .res_store_o(res_store), .res_exc_o(res_exc),
    .res_rdata_o(res_rdata),
    .port_ld_o(p_ld), .port_st_o(p_st), .port_addr_valid_o(p_av),
    .port_addr_o(p_addr), .port_wdata_o(p_wdata), .port_wvalid_o(p_wv),
    .port_busy_i(p_busy), .port_addr_ack_i(p_ack), .port_addr_exc_i(p_exc),
    .port_rvalid_i(p_rv), .port_rdata_i(p_rdata)
  );

  // behavioural port responder with a 16-word memory
  logic [DW-1:0] mem [16];
  logic [1:0]    rph;
  logic [7:0]    rcnt;
  bit            r_exc = 0;
  logic [7:0]    r_ackd = 0, r_ldd = 0;
  logic          req;

  assign req     = p_ld || p_st;
  assign p_ack   = (rph == 2'd1) && (rcnt == 0) && !r_exc;
  assign p_exc   = (rph == 2'd1) && (rcnt == 0) && r_exc;
  assign p_rv    = (rph == 2'd2) && p_ld && (rcnt == 0);
  assign p_busy  = ((rph == 2'd0) && req) || ((rph == 2'd1) && !p_exc) ||
                   ((rph == 2'd2) && !p_rv && !p_wv);
  assign p_rdata = mem[p_addr[3:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rph  <= 2'd0;
      rcnt <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else if (kill) begin
      rph <= 2'd0;
    end else begin
      case (rph)
        2'd0: if (req) begin rph <= 2'd1; rcnt <= r_ackd; end
        2'd1: if (rcnt != 0) rcnt <= rcnt - 1;
              else begin rph <= r_exc ? 2'd3 : 2'd2; rcnt <= r_ldd; end
        2'd2: if (p_st) begin
                if (p_wv) begin mem[p_addr[3:0]] <= p_wdata; rph <= 2'd3; end
              end else if (rcnt != 0) rcnt <= rcnt - 1;
              else rph <= 2'd3;
        default: if (!req) rph <= 2'd0;
      endcase
    end
  end

  // scoreboard
  typedef struct {bit st; bit exc; logic [DW-1:0] data;} exp_t;
  exp_t q[$];
  logic [DW-1:0] shadow [16];
  int checks = 0, fails = 0, done_cnt = 0, issued = 0, cyc = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  int ack_c = -10, wv_c = -10, rv_c = -10, exc_c = -10, wv_n = 0;
  logic [AW-1:0] prev_addr = '0;
  bit prev_av = 0, prev_res = 0;

  always @(negedge clk) begin
    if (rst_n && !kill) begin
      if (p_ack) ack_c = cyc;
      if (p_exc) exc_c = cyc;
      if (p_rv)  rv_c  = cyc;
      if (prev_av && p_av) chk(p_addr == prev_addr, "R3", "addr held", p_addr, prev_addr);
      if (prev_res) begin
        chk(cmd_ready == 1'b1, "R1", "ready after result", cmd_ready, 1);
        chk(res_valid == 1'b0, "R11", "result one cycle", res_valid, 0);
      end
      if (p_wv) begin
        wv_c = cyc;
        wv_n++;
        chk(cyc == ack_c + 1, "R4", "wvalid cycle after ack", cyc - ack_c, 1);
        chk(q.size() > 0 && q[0].st && p_wdata == q[0].data, "R4", "store data",
            p_wdata, q.size() > 0 ? q[0].data : 0);
      end
      if (res_valid) begin
        chk(!p_ld && !p_st && !cmd_ready, "R8", "strobes/ready low at result",
            {p_ld, p_st, cmd_ready}, 0);
        if (q.size() == 0) begin
          chk(0, "R9", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.exc) begin
            chk(res_exc && !res_store, "R6", "exc flags", {res_exc, res_store}, 2'b10);
            chk(cyc == exc_c + 1, "R6", "exc latency", cyc - exc_c, 1);
          end else if (e.st) begin
            chk(res_store && !res_exc, "R7", "store flags", {res_store, res_exc}, 2'b10);
            chk(cyc == wv_c + 2, "R7", "store latency", cyc - wv_c, 2);
            chk(wv_n == 1, "R4", "wvalid count", wv_n, 1);
          end else begin
            chk(!res_store && !res_exc, "R5", "load flags", {res_store, res_exc}, 0);
            chk(res_rdata == e.data, "R5", "load data", res_rdata, e.data);
            chk(cyc == rv_c + 1, "R5", "load latency", cyc - rv_c, 1);
          end
          if (!e.st || e.exc) chk(wv_n == 0, "R6", "no wvalid", wv_n, 0);
        end
        done_cnt++;
      end
      prev_av  = p_av;
      prev_addr = p_addr;
      prev_res = res_valid;
    end else begin
      prev_av = 0;
      prev_res = 0;
    end
  end

  task automatic issue(bit st, logic [AW-1:0] a, logic [DW-1:0] d, bit exc,
                       int ackd, int ldd, bit push);
    exp_t e;
    @(negedge clk);
    r_exc = exc; r_ackd = 8'(ackd); r_ldd = 8'(ldd);
    cmd_valid = 1; cmd_store = st; cmd_addr = a; cmd_wdata = d;
    wv_n = 0;
    e.st = st; e.exc = exc; e.data = st ? d : shadow[a[3:0]];
    if (st && !exc) shadow[a[3:0]] = d;
    if (push) q.push_back(e);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    issued += push;
    chk(p_st == st && p_ld == !st && p_av && p_addr == a, "R2", "strobe/addr",
        {p_st, p_ld, p_av}, {st, !st, 1'b1});
    chk(!cmd_ready, "R1", "ready low while busy", cmd_ready, 0);
  endtask

  task automatic run(bit st, logic [AW-1:0] a, logic [DW-1:0] d, bit exc, int ackd, int ldd);
    issue(st, a, d, exc, ackd, ldd, 1);
    wait (done_cnt == issued);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk(cmd_ready && !p_ld && !p_st && !p_av && !p_wv && !res_valid, "R10", "reset state",
        {cmd_ready, p_ld, p_st, p_av, p_wv, res_valid}, 6'b100000);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !p_av, "R10", "idle after reset", {cmd_ready, p_av}, 2'b10);

    run(1, 8'h03, 16'h1234, 0, 0, 0);   // R7 store, immediate accept
    run(0, 8'h03, 16'h0,    0, 0, 0);   // R5 store then load
    run(1, 8'h05, 16'hbeef, 0, 3, 0);   // R4 delayed accept
    run(0, 8'h05, 16'h0,    0, 1, 4);   // R5 delayed read data
    run(0, 8'h07, 16'h0,    0, 0, 2);   // R5 unwritten word
    run(1, 8'h09, 16'hdead, 1, 2, 0);   // R6 store exception
    run(0, 8'h09, 16'h0,    0, 0, 0);   // R6 memory untouched
    run(0, 8'h03, 16'h0,    1, 0, 0);   // R6 load exception
    run(1, 8'h03, 16'h5a5a, 0, 1, 0);
    run(0, 8'h03, 16'h0,    0, 0, 1);

    // R9 kill mid-load
    issue(0, 8'h0c, 16'h0, 0, 0, 20, 0);
    repeat (5) @(negedge clk);
    kill = 1;
    chk(!cmd_ready, "R9", "ready low under kill", cmd_ready, 0);
    @(negedge clk);
    chk(!p_ld && !p_st && !p_av && !p_wv, "R9", "port outputs low",
        {p_ld, p_st, p_av, p_wv}, 0);
    kill = 0;
    #1;
    chk(cmd_ready, "R9", "idle after kill", cmd_ready, 1);
    repeat (24) @(negedge clk);
    chk(!p_av && done_cnt == issued, "R8", "no strobe while idle", p_av, 0);

    for (int i = 0; i < 8; i++) run(1, 8'(16 + i * 2), 16'(i * 16'h111 + 1), 0, i % 3, 0);
    for (int i = 7; i >= 0; i--) run(0, 8'(16 + i * 2), 16'h0, 0, i % 2, i % 4);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R11", "all results seen", q.size(), 0);
    finish_run();
  end

endmodule